// File: doc/BRIEF.md
# Universal Latched/Registered Bus Transceiver

This block connects two buses, A and B, through two independent data paths: one carries A to B and one carries B to A. Each path has one storage element that works in three ways. It can be a transparent latch, a latch that holds its value, or a clock-enabled register that captures on a rising edge of that path's own data clock. Each path also has an active-low output enable that decides whether the stored value is driven onto the far bus.

The design is synthesizable, so each bus pin is split into three signals: an input value, a per-bit "driven from outside" flag, and a registered output value with an output-enable. Each path's data clock, latch enable, clock enable and output enable are sampled on the system clock. A rising edge of the data clock is detected from two samples in a row, one low and the next high. A keeper on every data input holds the last driven value of any bit whose drive flag is low. This stands in for the bus-hold function of a real pad.

All outputs are registered, so any change on the inputs shows at the outputs one system clock later.

Top module: `bus_xcvr_univ`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `a_out` and `b_out` are zero and `a_oe` and `b_oe` are low.
- R2: While a path's latch enable is high, its output equals the input it sampled on the previous system clock edge.
- R3: A high latch enable takes priority over the data clock: the output keeps tracking the input whatever the data clock and clock enable do.
- R4: While the latch enable is low and the data clock is not rising, the stored value does not change, even when the input changes.
- R5: With the latch enable low and the clock enable low, a sample of the data clock high that follows a low sample loads the input of that same cycle. The loaded value appears on the output one cycle later.
- R6: While the clock enable is high, rising data clock edges do not change the stored value.
- R7: A falling edge of the data clock never changes the stored value.
- R8: A path's output-enable output is the inverse of its active-low enable input, one cycle later. Turning the output off does not stop the storage from being updated. The test sequence never enables an output onto a bus that is being driven from outside.
- R9: The B-to-A path behaves like the A-to-B path, using its own four controls. Activity on one path leaves the other path's output unchanged.
- R10: Each data bit whose drive flag is 0 keeps the last value it had while its flag was 1. Bits that are driven pass their input straight through.
- R11: If the latch enable falls while the data clock is already high, no capture happens. The stored value stays the one from the last transparent cycle.
- R12: A data clock that is held high through the release of reset does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Value seen on bus A from outside |
| a_drv | input | W | Per-bit flag: bus A bit is driven from outside |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | W | Value seen on bus B from outside |
| b_drv | input | W | Per-bit flag: bus B bit is driven from outside |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B data clock (sampled) |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A data clock (sampled) |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |

## Verification
The assertions check the following on every cycle:
- the one-cycle tracking in transparent mode;
- that the stored value does not move while the data clock is low or the clock enable is high;
- the one-cycle delay of the output enable;
- that undriven bits keep their value.

Only the directed scenarios can show two behaviours. The first is that the correct value is captured on a detected rising edge. The second is what happens around the fall of the latch enable: no capture when the clock was already high, and capture when it rises afterwards. The scenarios also show that the two paths stay independent, that a data clock held high through reset is not taken as an edge, and that the bench never drives a bus the block is driving.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Control bundle of one transfer direction.
  typedef struct packed {
    logic oe_n;  // output enable, active low
    logic le;    // transparent when high
    logic tclk;  // data clock, sampled on the system clock
    logic ce_n;  // clock enable, active low
  } dir_ctrl_t;

  localparam int NUM_DIR = 2;  // index 0: A to B, index 1: B to A
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic prev;

  // Reset to one so a clock held high through reset is not an edge (R12).
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sig;
  end

  assign rise = sig & ~prev;

  p_single_rise_r5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] drv,
  output logic [W-1:0] kept
);
  logic [W-1:0] last;

  assign kept = (pin & drv) | (last & ~drv);

  always_ff @(posedge clk) begin
    if (rst) last <= '0;
    else     last <= kept;
  end

  // R10: an undriven bit keeps the value it had one cycle before.
  p_hold_undriven_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((~drv) & (kept ^ $past(kept))) == '0));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctrl_t    ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_en
);
  logic rise;

  xcvr_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  (ctl.tclk),
    .rise (rise)
  );

  // Merged latch and register: latch enable wins, else a qualified edge loads.
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      q_en <= 1'b0;
    end else begin
      q_en <= ~ctl.oe_n;
      if (ctl.le)
        q <= d;
      else if (rise && !ctl.ce_n)
        q <= d;
    end
  end

  p_track_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.le |=> (q == $past(d)));

  p_noedge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl.le && !ctl.tclk) |=> $stable(q));

  p_ce_block_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctl.le && ctl.ce_n) |=> $stable(q));

  p_oe_on_r8: assert property (@(posedge clk) disable iff (rst)
    !ctl.oe_n |=> q_en);

  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.oe_n |=> !q_en);
endmodule

// File: rtl/bus_xcvr_univ.sv
module bus_xcvr_univ
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_drv,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_drv,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_ce_n
);
  logic [W-1:0] src_pin [NUM_DIR];
  logic [W-1:0] src_drv [NUM_DIR];
  logic [W-1:0] held    [NUM_DIR];
  logic [W-1:0] dst_val [NUM_DIR];
  logic         dst_en  [NUM_DIR];
  dir_ctrl_t    ctl     [NUM_DIR];

  assign src_pin[0] = a_in;
  assign src_drv[0] = a_drv;
  assign ctl[0]     = '{oe_n: ab_oe_n, le: ab_le, tclk: ab_clk, ce_n: ab_ce_n};
  assign src_pin[1] = b_in;
  assign src_drv[1] = b_drv;
  assign ctl[1]     = '{oe_n: ba_oe_n, le: ba_le, tclk: ba_clk, ce_n: ba_ce_n};

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    xcvr_keeper #(.W(W)) u_keep (
      .clk  (clk),
      .rst  (rst),
      .pin  (src_pin[g]),
      .drv  (src_drv[g]),
      .kept (held[g])
    );

    xcvr_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl[g]),
      .d    (held[g]),
      .q    (dst_val[g]),
      .q_en (dst_en[g])
    );
  end

  assign b_out = dst_val[0];
  assign b_oe  = dst_en[0];
  assign a_out = dst_val[1];
  assign a_oe  = dst_en[1];

  // R9: a path whose controls keep it still does not move when the other does.
  p_ab_isolated_r9: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_ce_n) |=> $stable(b_out));
endmodule

// File: tb/tb_bus_xcvr_univ.sv
module tb_bus_xcvr_univ;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, a_drv, b_in, b_drv, a_out, b_out;
  logic a_oe, b_oe;
  logic ab_oe_n, ab_le, ab_clk, ab_ce_n, ba_oe_n, ba_le, ba_clk, ba_ce_n;

  int total = 0;
  int bad = 0;
  int conflicts = 0;

  always #10 clk = ~clk;

  bus_xcvr_univ #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Bus contention monitor, sampled between edges.
  always begin
    @(posedge clk);
    #3;
    if (rst === 1'b0 && ((a_oe && a_drv != '0) || (b_oe && b_drv != '0)))
      conflicts++;
  end

  task automatic t_reset;
    rst = 1'b1;
    a_in = 18'h15555; b_in = 18'h2AAAA; a_drv = '1; b_drv = '1;
    ab_oe_n = 1'b1; ab_le = 1'b0; ab_clk = 1'b1; ab_ce_n = 1'b0;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b1; ba_ce_n = 1'b0;
    tick(4);
    chk("R1 b_out in reset", b_out, '0);
    chk("R1 b_oe in reset", W'(b_oe), '0);
    rst = 1'b0;
    tick();
    chk("R1 a_out after reset", a_out, '0);
    chk("R1 a_oe after reset", W'(a_oe), '0);
    tick(2);
    chk("R12 held-high clock no capture", b_out, '0);
    chk("R12 held-high clock no capture B->A", a_out, '0);
  endtask

  task automatic t_transparent;
    b_drv = '0; ab_oe_n = 1'b0; ab_le = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] v;
      v = W'(18'h0B3C5 * (i + 3)) ^ W'(i << 7);
      a_in = v;
      tick();
      chk("R2 transparent tracking", b_out, v);
    end
    chk("R8 output enabled", W'(b_oe), W'(1));
  endtask

  task automatic t_le_priority;
    ab_le = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] v;
      v = W'(18'h3F00F >> i) ^ W'(i);
      ab_clk = i[0];
      ab_ce_n = i[1];
      a_in = v;
      tick();
      chk("R3 latch enable over clock", b_out, v);
    end
    // leave with clock low, ce low, last transparent value in store
    ab_clk = 1'b0; ab_ce_n = 1'b0; a_in = 18'h11111;
    tick();
    chk("R3 final transparent", b_out, 18'h11111);
  endtask

  task automatic t_capture;
    ab_le = 1'b0; a_in = 18'h22222;
    tick();
    chk("R4 hold with clock low", b_out, 18'h11111);
    a_in = 18'h2C0DE; ab_clk = 1'b1;
    tick();
    chk("R5 rising edge capture", b_out, 18'h2C0DE);
    a_in = 18'h33333;
    tick(2);
    chk("R4 hold with clock high", b_out, 18'h2C0DE);
    ab_clk = 1'b0; a_in = 18'h04444;
    tick();
    chk("R7 falling edge ignored", b_out, 18'h2C0DE);
  endtask

  task automatic t_ce_block;
    ab_ce_n = 1'b1; a_in = 18'h15A5A;
    tick();
    ab_clk = 1'b1;
    tick();
    chk("R6 edge ignored with ce high", b_out, 18'h2C0DE);
    ab_ce_n = 1'b0;
    tick();
    chk("R6 enabling ce is not an edge", b_out, 18'h2C0DE);
    ab_clk = 1'b0;
    tick();
    ab_clk = 1'b1;
    tick();
    chk("R5 capture after ce enabled", b_out, 18'h15A5A);
  endtask

  task automatic t_le_fall_hold;
    ab_le = 1'b1; ab_clk = 1'b1; a_in = 18'h3A3A3;
    tick();
    chk("R2 transparent before fall", b_out, 18'h3A3A3);
    ab_le = 1'b0; a_in = 18'h05F05;
    tick(2);
    chk("R11 no capture when clock already high", b_out, 18'h3A3A3);
    ab_le = 1'b1; ab_clk = 1'b0; a_in = 18'h12468;
    tick();
    ab_le = 1'b0; ab_clk = 1'b1; a_in = 18'h2BDF1;
    tick();
    chk("R5 capture when clock rises after fall", b_out, 18'h2BDF1);
  endtask

  task automatic t_oe;
    ab_oe_n = 1'b1;
    tick();
    chk("R8 output disabled", W'(b_oe), '0);
    chk("R8 stored value kept while off", b_out, 18'h2BDF1);
    ab_le = 1'b1; a_in = 18'h0ACE1;
    tick();
    chk("R8 storage updates while off", b_out, 18'h0ACE1);
    ab_le = 1'b0;
    ab_oe_n = 1'b0;
    tick();
    chk("R8 output re-enabled", W'(b_oe), W'(1));
    ab_oe_n = 1'b1;
    tick();
  endtask

  task automatic t_reverse;
    a_drv = '0; b_drv = '1; ab_ce_n = 1'b1;
    ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 18'h1D00D;
    tick();
    chk("R9 B->A transparent", a_out, 18'h1D00D);
    chk("R9 B->A output enabled", W'(a_oe), W'(1));
    chk("R9 A->B unchanged", b_out, 18'h0ACE1);
    ba_le = 1'b0; ba_ce_n = 1'b0; ba_clk = 1'b0; b_in = 18'h2FEED;
    tick();
    chk("R9 B->A hold", a_out, 18'h1D00D);
    ba_clk = 1'b1;
    tick();
    chk("R9 B->A edge capture", a_out, 18'h2FEED);
    chk("R9 A->B still unchanged", b_out, 18'h0ACE1);
    ba_oe_n = 1'b1;
    tick();
    chk("R9 B->A output disabled", W'(a_oe), '0);
  endtask

  task automatic t_bushold;
    logic [W-1:0] mask, exp;
    b_drv = '0; ab_le = 1'b1; a_drv = '1; a_in = 18'h3C3C3;
    tick();
    chk("R10 driven pass-through", b_out, 18'h3C3C3);
    mask = 18'h000FF;
    a_drv = mask; a_in = 18'h05A5A;
    exp = (18'h05A5A & mask) | (18'h3C3C3 & ~mask);
    tick();
    chk("R10 partial drive keeps undriven bits", b_out, exp);
    a_drv = '0; a_in = 18'h2FFFF;
    tick(2);
    chk("R10 all undriven holds", b_out, exp);
    a_drv = '1; a_in = 18'h2FFFF;
    tick();
    chk("R10 redriven", b_out, 18'h2FFFF);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_le_priority();
    t_capture();
    t_ce_block();
    t_le_fall_hold();
    t_oe();
    t_reverse();
    t_bushold();
    tick();
    chk("R8 no bus contention", W'(conflicts), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule